// File: doc/BRIEF.md
# GPIO Bank Controller with Atomic Set/Clear Registers

This block controls one bank of up to 32 general-purpose pins. Through a simple 32-bit register port, software sets the direction of each pin and the value it drives. It also chooses which pins watch for rising edges, falling edges or both. The block drives a per-pin output enable and output value toward the pads. It reads the pad levels back through a two-flop synchronizer.

Direction, output value and both edge enables each have a pair of write-one-to-set and write-one-to-clear registers. A driver can therefore change a single pin with one write and never has to read, modify and write back. A detected edge on an enabled pin is latched in a status register, and software clears it by writing 1 to the bit. The interrupt output is raised while any latched status bit is also allowed by the mask register. A system with up to 128 pins uses four instances: pin n goes to instance n/32, bit n%32.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, `pad_oe`, `pad_out`, the direction, the edge enables, the edge status, the mask and `irq` are all zero.
- R2: A write to byte offset 0x18 sets `pad_out` high for every bit that is 1 in `wdata`. Bits that are 0 keep their value. The change is visible after the clock edge that takes the write.
- R3: A write to offset 0x24 drives `pad_out` low for every bit that is 1 in `wdata`. Bits that are 0 keep their value.
- R4: A 1 written to offset 0x54 makes that pin an output (`pad_oe` bit = 1). A 1 written to offset 0x60 makes it an input. Offset 0x0C is written directly and reads back the current direction.
- R5: A read at offset 0x00 returns `pad_in` as seen through two flops. A change on `pad_in` first shows up after the second rising clock edge.
- R6: The rising-edge enables are written directly at 0x30 (which reads them back), set at 0x6C and cleared at 0x78. An enabled rising edge sets the pin's bit in the edge status at offset 0x48.
- R7: The falling-edge enables are written directly at 0x3C (which reads them back), set at 0x84 and cleared at 0x90. An enabled falling edge sets the status bit. A pin with both enables set records edges in both directions.
- R8: An edge on a pin whose matching enable is 0 leaves its status bit unchanged.
- R9: Writing 1 to a bit at offset 0x48 clears that status bit, and bits written 0 are kept. If a new enabled edge arrives in the cycle of the clear, the bit stays 1.
- R10: `irq` is 1 exactly when some status bit is 1 and the matching bit of the mask at offset 0x9C is 1. The mask reads back.
- R11: The set and clear offsets (0x18, 0x24, 0x54, 0x60, 0x6C, 0x78, 0x84, 0x90) and any unmapped or unaligned offset read as zero. A write to an unmapped or unaligned offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output value |
| irq | output | 1 | Masked edge interrupt |

## Verification
Set and clear words with overlapping and disjoint bit patterns tell a correct bitwise update apart from a whole-word overwrite, and from a swap of the set and clear registers. The edge tests use four pins with the enable combinations rise-only, fall-only, both and none, driven through one rising and one falling transition. These separate the polarity decoding and show that disabled pins stay quiet. A level read one cycle after a pad change, and again a cycle later, pins down the synchronizer depth. A status clear issued in exactly the cycle a new edge is detected shows that the set takes priority over the clear.

// File: rtl/gpio_bank_pkg.sv
// gpio_bank_pkg: register offsets and shared types for the GPIO bank.
// Assumes byte addressing of 32-bit words; offsets are fixed at a 12-byte stride.
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LEVEL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RISE     = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_FALL     = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_DIR_SET  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h9C;

    // Write strobes for a register with direct, set and clear access.
    typedef struct packed {
        logic direct;
        logic set;
        logic clr;
    } sc_wr_t;

endpackage

// File: rtl/gpio_setclr_reg.sv
// gpio_setclr_reg: a W-bit register updated by a direct write, a bitwise set,
// or a bitwise clear. Assumes at most one strobe is active per cycle
// (the decoder selects one offset per cycle).
module gpio_setclr_reg
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sc_wr_t       wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Hold, overwrite, or apply the bitwise set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr.direct)
            q <= wdata;
        else if (wr.set)
            q <= q | wdata;
        else if (wr.clr)
            q <= q & ~wdata;
    end

    assert_set_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr.set |=> ((q & $past(wdata)) == $past(wdata)));

    assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr.set |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    assert_clr_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr.clr |=> ((q & $past(wdata)) == '0));

    assert_clr_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr.clr |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.direct || wr.set || wr.clr) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
// gpio_in_sync: two-flop synchronizer on the pad inputs plus one history flop.
// Flags rising and falling transitions of the synchronized level.
// Assumes pad inputs are asynchronous and each pin is treated independently.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Synchronizer chain and one cycle of history for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Transition flags relative to the previous synchronized value.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end

    assert_edges_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & fall) == '0);

    assert_level_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_q == $past(level)));

endmodule

// File: rtl/gpio_edge_status.sv
// gpio_edge_status: sticky per-pin edge status with write-one-to-clear.
// Assumes rise/fall come from gpio_in_sync; a new edge beats a simultaneous clear.
module gpio_edge_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    logic [W-1:0] hit;
    logic [W-1:0] clr_bits;

    // Qualify edges with their enables; form the clear vector.
    always_comb begin
        hit      = (rise & rise_en) | (fall & fall_en);
        clr_bits = clr_en ? clr_mask : '0;
    end

    // Latch qualified edges; clear only bits without a new edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_bits) | hit;
    end

    assert_edge_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((status & $past(status)) == $past(status)));

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(rise | fall)) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// gpio_bank_ctrl: one GPIO bank behind a 32-bit register port.
// Decodes byte offsets, holds direction/output/edge-enable/mask state and
// raises irq from masked edge status. Assumes single-cycle writes and a
// combinational read mux; NPINS must not exceed 32.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out
    ,
    output logic              irq
);

    localparam int DW = 32;

    sc_wr_t           out_wr, dir_wr, rise_wr, fall_wr;
    logic             status_clr;
    logic             mask_wr;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] out_q, dir_q, rise_en, fall_en, mask_q, status;
    logic [NPINS-1:0] level, rise, fall;

    // Decode the write offset into per-register strobes.
    always_comb begin
        out_wr     = '0;
        dir_wr     = '0;
        rise_wr    = '0;
        fall_wr    = '0;
        status_clr = 1'b0;
        mask_wr    = 1'b0;
        wbits      = wdata[NPINS-1:0];
        if (wr_en) begin
            case (addr)
                OFS_OUT_SET:  out_wr.set     = 1'b1;
                OFS_OUT_CLR:  out_wr.clr     = 1'b1;
                OFS_DIR:      dir_wr.direct  = 1'b1;
                OFS_DIR_SET:  dir_wr.set     = 1'b1;
                OFS_DIR_CLR:  dir_wr.clr     = 1'b1;
                OFS_RISE:     rise_wr.direct = 1'b1;
                OFS_RISE_SET: rise_wr.set    = 1'b1;
                OFS_RISE_CLR: rise_wr.clr    = 1'b1;
                OFS_FALL:     fall_wr.direct = 1'b1;
                OFS_FALL_SET: fall_wr.set    = 1'b1;
                OFS_FALL_CLR: fall_wr.clr    = 1'b1;
                OFS_STATUS:   status_clr     = 1'b1;
                OFS_MASK:     mask_wr        = 1'b1;
                default:      ;
            endcase
        end
    end

    gpio_setclr_reg #(.W(NPINS)) u_out_reg  (.clk(clk), .rst_n(rst_n), .wr(out_wr),  .wdata(wbits), .q(out_q));
    gpio_setclr_reg #(.W(NPINS)) u_dir_reg  (.clk(clk), .rst_n(rst_n), .wr(dir_wr),  .wdata(wbits), .q(dir_q));
    gpio_setclr_reg #(.W(NPINS)) u_rise_reg (.clk(clk), .rst_n(rst_n), .wr(rise_wr), .wdata(wbits), .q(rise_en));
    gpio_setclr_reg #(.W(NPINS)) u_fall_reg (.clk(clk), .rst_n(rst_n), .wr(fall_wr), .wdata(wbits), .q(fall_en));

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .level(level), .rise(rise), .fall(fall)
    );

    gpio_edge_status #(.W(NPINS)) u_status (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .rise_en(rise_en), .fall_en(fall_en),
        .clr_en(status_clr), .clr_mask(wbits), .status(status)
    );

    // Interrupt mask register, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= wbits;
    end

    // Drive pads and interrupt from held state.
    always_comb begin
        pad_oe  = dir_q;
        pad_out = out_q;
        irq     = |(status & mask_q);
    end

    // Read mux; set/clear and unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_LEVEL:  rdata[NPINS-1:0] = level;
            OFS_DIR:    rdata[NPINS-1:0] = dir_q;
            OFS_RISE:   rdata[NPINS-1:0] = rise_en;
            OFS_FALL:   rdata[NPINS-1:0] = fall_en;
            OFS_STATUS: rdata[NPINS-1:0] = status;
            OFS_MASK:   rdata[NPINS-1:0] = mask_q;
            default:    rdata = '0;
        endcase
    end

    initial begin
        assert_width_fits_R11: assert (NPINS >= 1 && NPINS <= DW);
    end

    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1:0] != 2'b00) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(mask_q)));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        rd(8'h0C, v); chk("R1 dir", v, 0);
        rd(8'h48, v); chk("R1 status", v, 0);
        rd(8'h9C, v); chk("R1 mask", v, 0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(8'h18, 32'h0000_00F0); chk("R2 set", pad_out, 32'h0000_00F0);
        wr(8'h18, 32'h0F00_0001); chk("R2 set keeps", pad_out, 32'h0F00_00F1);
        wr(8'h24, 32'h0000_0030); chk("R3 clear", pad_out, 32'h0F00_00C1);
        wr(8'h24, 32'h0F00_0000); chk("R3 clear keeps", pad_out, 32'h0000_00C1);
        rd(8'h18, v); chk("R11 out-set reads 0", v, 0);
        rd(8'h24, v); chk("R11 out-clear reads 0", v, 0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(8'h54, 32'h0000_00FF); chk("R4 dir set", pad_oe, 32'h0000_00FF);
        wr(8'h60, 32'h0000_000F); chk("R4 dir clear", pad_oe, 32'h0000_00F0);
        rd(8'h0C, v); chk("R4 dir readback", v, 32'h0000_00F0);
        wr(8'h0C, 32'h1234_5678); chk("R4 dir direct", pad_oe, 32'h1234_5678);
        rd(8'h0C, v); chk("R4 dir direct readback", v, 32'h1234_5678);
        rd(8'h54, v); chk("R11 dir-set reads 0", v, 0);
        rd(8'h60, v); chk("R11 dir-clear reads 0", v, 0);
    endtask

    task automatic t_level();
        @(negedge clk);
        pad_in = 32'hA5A5_5A5A;
        addr = 8'h00;
        @(negedge clk); #1 chk("R5 level after 1 edge", rdata, 32'h0);
        @(negedge clk); #1 chk("R5 level after 2 edges", rdata, 32'hA5A5_5A5A);
        pad_in = 32'h0;
        settle();
    endtask

    task automatic t_edges();
        logic [31:0] v;
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h30, 32'h0000_0005);
        wr(8'h3C, 32'h0000_0006);
        rd(8'h30, v); chk("R6 rise readback", v, 32'h5);
        rd(8'h3C, v); chk("R7 fall readback", v, 32'h6);
        @(negedge clk); pad_in = 32'h0000_000F;
        settle();
        rd(8'h48, v); chk("R6 rising recorded", v, 32'h5);
        @(negedge clk); pad_in = 32'h0;
        settle();
        rd(8'h48, v); chk("R7 falling recorded", v, 32'h7);
        chk("R8 disabled pin quiet", v & 32'h8, 0);
        wr(8'h78, 32'h1); rd(8'h30, v); chk("R6 rise clear", v, 32'h4);
        wr(8'h6C, 32'h1); rd(8'h30, v); chk("R6 rise set", v, 32'h5);
        wr(8'h90, 32'h2); rd(8'h3C, v); chk("R7 fall clear", v, 32'h4);
        wr(8'h84, 32'h2); rd(8'h3C, v); chk("R7 fall set", v, 32'h6);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(8'h48, 32'h1);
        rd(8'h48, v); chk("R9 w1c", v, 32'h6);
        @(negedge clk); pad_in = 32'h4;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h48; wdata = 32'h4;
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R9 set beats clear", rdata, 32'h6);
        wr(8'h48, 32'h4);
        rd(8'h48, v); chk("R9 clear bit2", v, 32'h2);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        chk("R10 irq masked", {31'b0, irq}, 0);
        wr(8'h9C, 32'h2); chk("R10 irq on", {31'b0, irq}, 1);
        rd(8'h9C, v); chk("R10 mask readback", v, 32'h2);
        wr(8'h9C, 32'h4); chk("R10 irq other mask", {31'b0, irq}, 0);
        wr(8'h9C, 32'h2);
        wr(8'h48, 32'h2); chk("R10 irq after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [31:0] oe0, out0;
        oe0 = pad_oe; out0 = pad_out;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R11 unmapped reads 0", v, 0);
        wr(8'h19, 32'hFFFF_FFFF); chk("R11 unaligned write ignored", pad_out, out0);
        wr(8'h55, 32'hFFFF_FFFF); chk("R11 unaligned dir ignored", pad_oe, oe0);
        rd(8'hA0, v); chk("R11 past end reads 0", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_output();
        t_dir();
        t_level();
        t_edges();
        t_w1c();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule